// File: doc/BRIEF.md
# Pointer Address Generator for Signal-Processing Memory Accesses

This block turns a pointer register and an access request into one data-memory address per cycle. It holds a small file of pointer registers. Each request selects a pointer, an addressing mode, a step source, an access size and an arithmetic kind. The address is formed combinationally in the same cycle. The selected pointer is rewritten on the clock edge that accepts the request. The step arithmetic can be plain two's-complement, circular within an aligned power-of-two window, or bit-reversed within a configurable index width. Because of this, FFT reordering and ring-buffer filters spend no extra instructions on address checks.

Requests arrive on a valid/ready pair and addresses leave on a second valid/ready pair, with no storage between them. `addr_valid` follows `req_valid`, and `req_ready` follows `addr_ready`. A request is consumed only in a cycle where both `req_valid` and `addr_ready` are high. While the consumer holds `addr_ready` low, the request and its address stay on the pins and no pointer changes. Configuration ports write pointers, two window-size registers and the bit-reverse width. They work in any cycle and need no handshake. A chip that needs two address streams instantiates the block twice.

Top module: `agu_core`

## Requirements
- R1: After reset every pointer reads as 0. An indirect request (mode 0) on any pointer then gives address 0, and `addr_valid` is low while `req_valid` is low.
- R2: Mode 0 (indirect) and mode 7 give the selected pointer as the address and leave the pointer unchanged.
- R3: Post-increment (mode 2) and post-decrement (mode 4) give the current pointer as the address. The pointer becomes the pointer plus or minus the scaled step on the accepting edge.
- R4: Pre-increment (mode 1) and pre-decrement (mode 3) give the stepped value as the address. That same value is written to the pointer.
- R5: Offset-plus (mode 5) and offset-minus (mode 6) give the pointer plus or minus the scaled step as the address, and the pointer is not written.
- R6: The step is shifted left by the size code before use: 0 is byte (x1), 1 is half-word (x2), 2 or 3 is word (x4).
- R7: With `req_use_imm` high, the step is the 5-bit unsigned `req_imm` (0..31). Otherwise it is `req_step`.
- R8: Circular arithmetic (`req_arith`=1) with window log2 size L keeps all pointer bits above bit L-1. Stepping past the top of the window continues from the window base.
- R9: In circular arithmetic, stepping below the window base continues from the top of the window.
- R10: `req_len_sel` picks which of the two window-size registers applies to a circular request.
- R11: In bit-reversed arithmetic (`req_arith`=2) with width F and word size, repeated post-increments by 1 from base B give B + 4*k for k = 0,4,2,6,1,5,3,7 when F=3, and then return to B.
- R12: `addr_valid` equals `req_valid` and `req_ready` equals `addr_ready`. No pointer changes in a cycle without a handshake.
- R13: A configuration write to a pointer takes priority over a write-back to the same pointer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_ptr | input | 3 | Pointer register select |
| req_mode | input | 3 | Addressing mode code (R2 to R5) |
| req_arith | input | 2 | 0 linear, 1 circular, 2 bit-reversed, 3 linear |
| req_size | input | 2 | Access size code for step scaling |
| req_use_imm | input | 1 | Select 5-bit immediate as step |
| req_imm | input | 5 | Unsigned immediate step |
| req_step | input | 16 | Register step value |
| req_len_sel | input | 1 | Window-size register select |
| addr_valid | output | 1 | Address present |
| addr_ready | input | 1 | Consumer can take the address |
| addr_out | output | 16 | Generated address |
| cfg_ptr_we | input | 1 | Pointer write strobe |
| cfg_ptr_idx | input | 3 | Pointer to write |
| cfg_ptr_data | input | 16 | Pointer write value |
| cfg_len_we | input | 1 | Window-size write strobe |
| cfg_len_idx | input | 1 | Window-size register to write |
| cfg_len_log2 | input | 5 | log2 of window size in bytes (16 means whole space) |
| cfg_fft_we | input | 1 | Bit-reverse width write strobe |
| cfg_fft_log2 | input | 5 | Number of reversed index bits |

## Verification
Two actions can fall in the same cycle. One is a pointer write-back from an accepted post-increment. The other is a configuration write to the very same pointer. The bench provokes this by driving both on one edge. It then reads the pointer back through an indirect request and expects the configured value, not the stepped one. A second collision is a pending request held under back-pressure while the clock runs. That case is judged by checking that the next accepted indirect request still returns the untouched pointer.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_IND      = 3'd0,
    AM_PREINC   = 3'd1,
    AM_POSTINC  = 3'd2,
    AM_PREDEC   = 3'd3,
    AM_POSTDEC  = 3'd4,
    AM_OFSPLUS  = 3'd5,
    AM_OFSMINUS = 3'd6,
    AM_IND_ALT  = 3'd7
  } agu_mode_e;

  typedef enum logic [1:0] {
    AR_LIN  = 2'd0,
    AR_CIRC = 2'd1,
    AR_BREV = 2'd2,
    AR_LIN2 = 2'd3
  } agu_arith_e;
endpackage

// File: rtl/agu_step.sv
module agu_step #(
  parameter int AW = 16,
  parameter int LW = 5,
  parameter int FW = 5
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] delta,
  input  logic [AW-1:0] raw,
  input  logic [1:0]    sh,
  input  logic          sub,
  input  logic [1:0]    arith,
  input  logic [LW-1:0] len_log2,
  input  logic [FW-1:0] fft_log2,
  output logic [AW-1:0] nxt
);
  import agu_pkg::*;

  function automatic logic [AW-1:0] low_mask(input int unsigned n);
    logic [AW-1:0] m;
    m = '0;
    for (int i = 0; i < AW; i++) begin
      if (i < int'(n)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [AW-1:0] mirror(input logic [AW-1:0] x, input int unsigned n);
    logic [AW-1:0] r;
    r = '0;
    for (int i = 0; i < AW; i++) begin
      if (i < int'(n)) r[i] = x[int'(n) - 1 - i];
    end
    return r;
  endfunction

  logic [AW-1:0] lin_sum, win_mask, circ_val;
  logic [AW-1:0] fld_mask, idx, rev_idx, rev_sum, new_idx, brev_val;

  always_comb begin
    lin_sum  = sub ? (cur - delta) : (cur + delta);
    win_mask = low_mask(int'(len_log2));
    circ_val = (cur & ~win_mask) | (lin_sum & win_mask);

    fld_mask = low_mask(int'(fft_log2));
    idx      = (cur >> sh) & fld_mask;
    rev_idx  = mirror(idx, int'(fft_log2));
    rev_sum  = (sub ? (rev_idx - raw) : (rev_idx + raw)) & fld_mask;
    new_idx  = mirror(rev_sum, int'(fft_log2)) & fld_mask;
    brev_val = (cur & ~(fld_mask << sh)) | (new_idx << sh);

    unique case (arith)
      AR_CIRC: nxt = circ_val;
      AR_BREV: nxt = brev_val;
      default: nxt = lin_sum;
    endcase
  end
endmodule

// File: rtl/agu_regs.sv
module agu_regs #(
  parameter int NP = 8,
  parameter int NL = 2,
  parameter int AW = 16,
  parameter int LW = 5,
  parameter int FW = 5,
  localparam int PIW = $clog2(NP),
  localparam int LSW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [PIW-1:0]    upd_idx,
  input  logic [AW-1:0]     upd_val,
  input  logic              cfg_ptr_we,
  input  logic [PIW-1:0]    cfg_ptr_idx,
  input  logic [AW-1:0]     cfg_ptr_data,
  input  logic              cfg_len_we,
  input  logic [LSW-1:0]    cfg_len_idx,
  input  logic [LW-1:0]     cfg_len_log2,
  input  logic              cfg_fft_we,
  input  logic [FW-1:0]     cfg_fft_log2,
  input  logic [PIW-1:0]    rd_idx,
  input  logic [LSW-1:0]    rd_len_sel,
  output logic [AW-1:0]     rd_ptr,
  output logic [LW-1:0]     rd_len,
  output logic [FW-1:0]     fft_q,
  output logic [NP*AW-1:0]  ptr_flat
);
  logic [AW-1:0] ptr_q [NP];
  logic [LW-1:0] len_q [NL];

  for (genvar p = 0; p < NP; p++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ptr_q[p] <= '0;
      else if (cfg_ptr_we && cfg_ptr_idx == PIW'(p))
        ptr_q[p] <= cfg_ptr_data;
      else if (upd_en && upd_idx == PIW'(p))
        ptr_q[p] <= upd_val;
    end
    assign ptr_flat[p*AW +: AW] = ptr_q[p];
  end

  for (genvar l = 0; l < NL; l++) begin : g_len
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        len_q[l] <= LW'(AW);
      else if (cfg_len_we && cfg_len_idx == LSW'(l))
        len_q[l] <= cfg_len_log2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fft_q <= '0;
    else if (cfg_fft_we) fft_q <= cfg_fft_log2;
  end

  assign rd_ptr = ptr_q[rd_idx];
  assign rd_len = len_q[rd_len_sel];
endmodule

// File: rtl/agu_core.sv
module agu_core #(
  parameter int NP   = 8,
  parameter int NL   = 2,
  parameter int AW   = 16,
  parameter int IMMW = 5,
  localparam int PIW = $clog2(NP),
  localparam int LSW = (NL > 1) ? $clog2(NL) : 1,
  localparam int LW  = $clog2(AW + 1),
  localparam int FW  = $clog2(AW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PIW-1:0]  req_ptr,
  input  logic [2:0]      req_mode,
  input  logic [1:0]      req_arith,
  input  logic [1:0]      req_size,
  input  logic            req_use_imm,
  input  logic [IMMW-1:0] req_imm,
  input  logic [AW-1:0]   req_step,
  input  logic [LSW-1:0]  req_len_sel,
  output logic            addr_valid,
  input  logic            addr_ready,
  output logic [AW-1:0]   addr_out,
  input  logic            cfg_ptr_we,
  input  logic [PIW-1:0]  cfg_ptr_idx,
  input  logic [AW-1:0]   cfg_ptr_data,
  input  logic            cfg_len_we,
  input  logic [LSW-1:0]  cfg_len_idx,
  input  logic [LW-1:0]   cfg_len_log2,
  input  logic            cfg_fft_we,
  input  logic [FW-1:0]   cfg_fft_log2
);
  import agu_pkg::*;

  logic [AW-1:0]    cur_ptr, step_raw, step_scaled, nxt_ptr;
  logic [LW-1:0]    cur_len;
  logic [FW-1:0]    cur_fft;
  logic [1:0]       sh;
  logic             fire, sub, writes_back, use_new;
  logic [NP*AW-1:0] ptr_flat;

  assign fire       = req_valid && addr_ready;
  assign req_ready  = addr_ready;
  assign addr_valid = req_valid;

  always_comb begin
    sh          = (req_size == 2'd3) ? 2'd2 : req_size;
    step_raw    = req_use_imm ? AW'(req_imm) : req_step;
    step_scaled = step_raw << sh;
    sub         = 1'b0;
    writes_back = 1'b0;
    use_new     = 1'b0;
    unique case (agu_mode_e'(req_mode))
      AM_PREINC:   begin writes_back = 1'b1; use_new = 1'b1; end
      AM_POSTINC:  begin writes_back = 1'b1; end
      AM_PREDEC:   begin writes_back = 1'b1; use_new = 1'b1; sub = 1'b1; end
      AM_POSTDEC:  begin writes_back = 1'b1; sub = 1'b1; end
      AM_OFSPLUS:  begin use_new = 1'b1; end
      AM_OFSMINUS: begin use_new = 1'b1; sub = 1'b1; end
      default:     ;
    endcase
    addr_out = use_new ? nxt_ptr : cur_ptr;
  end

  agu_regs #(.NP(NP), .NL(NL), .AW(AW), .LW(LW), .FW(FW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_en       (fire && writes_back),
    .upd_idx      (req_ptr),
    .upd_val      (nxt_ptr),
    .cfg_ptr_we   (cfg_ptr_we),
    .cfg_ptr_idx  (cfg_ptr_idx),
    .cfg_ptr_data (cfg_ptr_data),
    .cfg_len_we   (cfg_len_we),
    .cfg_len_idx  (cfg_len_idx),
    .cfg_len_log2 (cfg_len_log2),
    .cfg_fft_we   (cfg_fft_we),
    .cfg_fft_log2 (cfg_fft_log2),
    .rd_idx       (req_ptr),
    .rd_len_sel   (req_len_sel),
    .rd_ptr       (cur_ptr),
    .rd_len       (cur_len),
    .fft_q        (cur_fft),
    .ptr_flat     (ptr_flat)
  );

  agu_step #(.AW(AW), .LW(LW), .FW(FW)) u_step (
    .cur      (cur_ptr),
    .delta    (step_scaled),
    .raw      (step_raw),
    .sh       (sh),
    .sub      (sub),
    .arith    (req_arith),
    .len_log2 (cur_len),
    .fft_log2 (cur_fft),
    .nxt      (nxt_ptr)
  );
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int NP  = 8,
  parameter int AW  = 16,
  parameter int PIW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            addr_ready,
  input logic [PIW-1:0]  req_ptr,
  input logic [2:0]      req_mode,
  input logic [AW-1:0]   addr_out,
  input logic            cfg_ptr_we,
  input logic [PIW-1:0]  cfg_ptr_idx,
  input logic [AW-1:0]   cfg_ptr_data,
  input logic [NP*AW-1:0] ptr_flat
);
  logic hs;
  logic clash;
  assign hs    = req_valid && addr_ready;
  assign clash = cfg_ptr_we && (cfg_ptr_idx == req_ptr);

  // R2
  ind_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_mode == 3'd0 && !cfg_ptr_we) |=>
      ptr_flat[$past(req_ptr)*AW +: AW] == $past(ptr_flat[req_ptr*AW +: AW]));

  // R3
  post_uses_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_mode == 3'd2) |-> addr_out == ptr_flat[req_ptr*AW +: AW]);

  // R4
  pre_writes_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_mode == 3'd1 && !clash) |=>
      ptr_flat[$past(req_ptr)*AW +: AW] == $past(addr_out));

  // R12
  stall_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && addr_ready) && !cfg_ptr_we) |=> ptr_flat == $past(ptr_flat));

  // R13
  cfg_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ptr_we |=> ptr_flat[$past(cfg_ptr_idx)*AW +: AW] == $past(cfg_ptr_data));
endmodule

bind agu_core agu_chk #(.NP(NP), .AW(AW), .PIW(PIW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .addr_ready   (addr_ready),
  .req_ptr      (req_ptr),
  .req_mode     (req_mode),
  .addr_out     (addr_out),
  .cfg_ptr_we   (cfg_ptr_we),
  .cfg_ptr_idx  (cfg_ptr_idx),
  .cfg_ptr_data (cfg_ptr_data),
  .ptr_flat     (ptr_flat)
);

// File: tb/tb_agu_core.sv
module tb_agu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_ptr = '0, req_mode = '0;
  logic [1:0]  req_arith = '0, req_size = '0;
  logic        req_use_imm = 1'b0;
  logic [4:0]  req_imm = '0;
  logic [15:0] req_step = '0;
  logic        req_len_sel = 1'b0;
  logic        addr_valid, addr_ready = 1'b1;
  logic [15:0] addr_out;
  logic        cfg_ptr_we = 1'b0;
  logic [2:0]  cfg_ptr_idx = '0;
  logic [15:0] cfg_ptr_data = '0;
  logic        cfg_len_we = 1'b0, cfg_len_idx = 1'b0;
  logic [4:0]  cfg_len_log2 = '0;
  logic        cfg_fft_we = 1'b0;
  logic [4:0]  cfg_fft_log2 = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  agu_core dut (.*);

  // fields: ptr3 mode3 arith2 size2 useimm1 imm5 step16 lsel1 exp16
  localparam int NV = 24;
  localparam logic [48:0] VEC [NV] = '{
    {3'd0,3'd0,2'd0,2'd0,1'b0,5'd0, 16'd0, 1'b0,16'h0100},
    {3'd0,3'd2,2'd0,2'd0,1'b0,5'd0, 16'd4, 1'b0,16'h0100},
    {3'd0,3'd0,2'd0,2'd0,1'b0,5'd0, 16'd0, 1'b0,16'h0104},
    {3'd0,3'd1,2'd0,2'd1,1'b1,5'd3, 16'd0, 1'b0,16'h010A},
    {3'd0,3'd4,2'd0,2'd2,1'b1,5'd1, 16'd0, 1'b0,16'h010A},
    {3'd0,3'd0,2'd0,2'd0,1'b0,5'd0, 16'd0, 1'b0,16'h0106},
    {3'd0,3'd3,2'd0,2'd0,1'b0,5'd0, 16'd2, 1'b0,16'h0104},
    {3'd0,3'd5,2'd0,2'd0,1'b1,5'd31,16'd0, 1'b0,16'h0123},
    {3'd0,3'd6,2'd0,2'd1,1'b0,5'd0, 16'd16,1'b0,16'h00E4},
    {3'd0,3'd0,2'd0,2'd0,1'b0,5'd0, 16'd0, 1'b0,16'h0104},
    {3'd2,3'd2,2'd1,2'd2,1'b1,5'd1, 16'd0, 1'b0,16'h030C},
    {3'd2,3'd0,2'd1,2'd0,1'b0,5'd0, 16'd0, 1'b0,16'h0300},
    {3'd2,3'd3,2'd1,2'd0,1'b1,5'd1, 16'd0, 1'b0,16'h030F},
    {3'd2,3'd2,2'd1,2'd0,1'b1,5'd2, 16'd0, 1'b1,16'h030F},
    {3'd2,3'd0,2'd1,2'd0,1'b0,5'd0, 16'd0, 1'b1,16'h0309},
    {3'd1,3'd2,2'd2,2'd2,1'b1,5'd1, 16'd0, 1'b0,16'h0200},
    {3'd1,3'd2,2'd2,2'd2,1'b1,5'd1, 16'd0, 1'b0,16'h0210},
    {3'd1,3'd2,2'd2,2'd2,1'b1,5'd1, 16'd0, 1'b0,16'h0208},
    {3'd1,3'd2,2'd2,2'd2,1'b1,5'd1, 16'd0, 1'b0,16'h0218},
    {3'd1,3'd2,2'd2,2'd2,1'b1,5'd1, 16'd0, 1'b0,16'h0204},
    {3'd1,3'd2,2'd2,2'd2,1'b1,5'd1, 16'd0, 1'b0,16'h0214},
    {3'd1,3'd2,2'd2,2'd2,1'b1,5'd1, 16'd0, 1'b0,16'h020C},
    {3'd1,3'd2,2'd2,2'd2,1'b1,5'd1, 16'd0, 1'b0,16'h021C},
    {3'd1,3'd2,2'd2,2'd2,1'b1,5'd1, 16'd0, 1'b0,16'h0200}
  };

  function automatic string vec_tag(input int i);
    if (i < 1)  return "R2";
    if (i < 3)  return "R3";
    if (i < 4)  return "R4/R6/R7";
    if (i < 6)  return "R3/R6";
    if (i < 7)  return "R4";
    if (i < 8)  return "R5/R7";
    if (i < 10) return "R5";
    if (i < 12) return "R8";
    if (i < 13) return "R9";
    if (i < 15) return "R10";
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_ptr(input logic [2:0] idx, input logic [15:0] val);
    @(negedge clk);
    cfg_ptr_we = 1'b1; cfg_ptr_idx = idx; cfg_ptr_data = val;
    @(negedge clk);
    cfg_ptr_we = 1'b0;
  endtask

  task automatic set_req(input logic [2:0] p, input logic [2:0] m, input logic [1:0] a,
                         input logic [1:0] s, input logic ui, input logic [4:0] im,
                         input logic [15:0] st, input logic ls);
    req_ptr = p; req_mode = m; req_arith = a; req_size = s;
    req_use_imm = ui; req_imm = im; req_step = st; req_len_sel = ls;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    set_req(3'd5, 3'd0, 2'd0, 2'd0, 1'b0, 5'd0, 16'd0, 1'b0);
    #5 check("R1 addr_valid idle", {15'd0, addr_valid}, 16'd0);
    check("R1 ptr5 after reset", addr_out, 16'h0000);

    // configuration
    cfg_ptr(3'd0, 16'h0100);
    cfg_ptr(3'd1, 16'h0200);
    cfg_ptr(3'd2, 16'h030C);
    cfg_ptr(3'd3, 16'h0400);
    @(negedge clk);
    cfg_len_we = 1'b1; cfg_len_idx = 1'b0; cfg_len_log2 = 5'd4;
    @(negedge clk);
    cfg_len_idx = 1'b1; cfg_len_log2 = 5'd3;
    cfg_fft_we = 1'b1; cfg_fft_log2 = 5'd3;
    @(negedge clk);
    cfg_len_we = 1'b0; cfg_fft_we = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      set_req(VEC[i][48:46], VEC[i][45:43], VEC[i][42:41], VEC[i][40:39],
              VEC[i][38], VEC[i][37:33], VEC[i][32:17], VEC[i][16]);
      req_valid = 1'b1; addr_ready = 1'b1;
      #5 check(vec_tag(i), addr_out, VEC[i][15:0]);
      @(negedge clk);
    end

    // R12: back-pressure holds request and pointer
    set_req(3'd3, 3'd2, 2'd0, 2'd0, 1'b0, 5'd0, 16'd8, 1'b0);
    addr_ready = 1'b0;
    #5 check("R12 addr_valid", {15'd0, addr_valid}, 16'd1);
    check("R12 req_ready", {15'd0, req_ready}, 16'd0);
    check("R12 addr held", addr_out, 16'h0400);
    @(negedge clk);
    @(negedge clk);
    addr_ready = 1'b1;
    set_req(3'd3, 3'd0, 2'd0, 2'd0, 1'b0, 5'd0, 16'd0, 1'b0);
    #5 check("R12 ptr untouched", addr_out, 16'h0400);
    @(negedge clk);

    // R13: config write wins over write-back
    set_req(3'd3, 3'd2, 2'd0, 2'd0, 1'b0, 5'd0, 16'd8, 1'b0);
    cfg_ptr_we = 1'b1; cfg_ptr_idx = 3'd3; cfg_ptr_data = 16'h0555;
    #5 check("R13 addr current", addr_out, 16'h0400);
    @(negedge clk);
    cfg_ptr_we = 1'b0;
    set_req(3'd3, 3'd0, 2'd0, 2'd0, 1'b0, 5'd0, 16'd0, 1'b0);
    #5 check("R13 cfg value kept", addr_out, 16'h0555);

    // R2: mode 7 acts as indirect
    set_req(3'd3, 3'd7, 2'd0, 2'd0, 1'b0, 5'd0, 16'd8, 1'b0);
    @(negedge clk);
    set_req(3'd3, 3'd0, 2'd0, 2'd0, 1'b0, 5'd0, 16'd0, 1'b0);
    #5 check("R2 mode7 no write", addr_out, 16'h0555);
    @(negedge clk);
    req_valid = 1'b0;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule